// File: doc/BRIEF.md
# SPI Master with Chip-Select Hold

This block is a single-slave SPI master that moves one 16-bit word per transfer, MSB first, in both directions. Software drives it through one 32-bit write port with four byte enables. The low 16 bits hold the outgoing word. The top byte carries a chip-select hold flag and a two-bit selector that picks one of four clock-polarity settings. Writing either data byte lane starts a transfer. A write that touches only the top byte updates the hold flag and the format without sending anything.

The hold flag sets what the active-low chip select does once a word has finished. With hold set, chip select stays asserted, so a multi-word transaction to a serial memory sees it low the whole time. With hold clear, chip select is released half an SCLK period after the last edge. The clock half-period is a parameter counted in system clocks. MOSI changes on the trailing edge of each SCLK pulse and MISO is sampled on the leading edge. When a word completes, the received bits are copied into a readable buffer and a one-cycle done pulse is given.

Top module: `spi_hold_master`

## Requirements
- R1: After reset, cs_n is 1, busy is 0, done is 0, rx_data is 0, and sclk rests at the polarity of format 0.
- R2: A write accepted while idle with wr_be[0] or wr_be[1] set starts a transfer. MOSI carries the 16 data bits MSB first. A data byte lane left unwritten keeps its previous value (wr_be[0] covers bits 7:0, wr_be[1] covers bits 15:8).
- R3: MISO is sampled on each leading SCLK edge. At completion, rx_data holds the 16 sampled bits MSB first, and done is high for exactly one clock.
- R4: The hold flag is wr_data bit 28 and is written when wr_be[3] is set. At the end of a word with hold 1, cs_n stays 0. With hold 0, cs_n returns to 1 in the cycle done is high.
- R5: From the accepting write until done, cs_n never rises. Across consecutive words where the earlier word was held, cs_n stays low throughout.
- R6: A write with wr_be[1:0] = 0 starts no transfer: busy stays 0 and sclk does not toggle.
- R7: A control-only write with hold 0 while idle releases cs_n at the next clock, without toggling sclk.
- R8: wr_data bits 25:24 (with wr_be[3]) select the idle SCLK level from FMT_CPOL. By default, odd selectors idle high and even selectors idle low. A polarity change between words is not treated as a shift edge: each word has exactly 32 SCLK transitions and no extra received bit.
- R9: The first hold value written after reset takes effect at once, with no repeated write.
- R10: Writes that arrive while busy are ignored: data, hold flag and format all stay as they were.
- R11: cs_n is asserted at the accepting clock edge, and the first SCLK edge comes HALF_DIV clocks after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables for wr_data |
| wr_data | input | 32 | Data (15:0), format select (25:24), hold flag (28) |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a word completes |
| rx_data | output | 16 | Last received word |

## Verification
The bench changes clock polarity between two held words. A design that counted the level change as a shift edge would show 33 transitions and a rotated received word. It checks that chip select stays low across held words at every cycle, which catches a design that releases and reasserts chip select at the start of the next word. Control-only writes are tested to confirm they neither start shifting nor fail to drop a held chip select. A poke write during a transfer and a single-lane data write expose designs that accept writes while busy or clear the unwritten byte.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
    parameter int unsigned WORD_W     = 16;
    parameter int unsigned REG_W      = 32;
    parameter int unsigned BE_W       = REG_W / 8;
    parameter int unsigned DATA_LANES = WORD_W / 8;
    parameter int unsigned HOLD_BIT   = 28;
    parameter int unsigned FMT_LSB    = 24;
    parameter int unsigned FMT_W      = 2;
    parameter int unsigned NFMT       = 1 << FMT_W;
    parameter int unsigned CTRL_LANE  = 3;
    parameter int unsigned EDGE_W     = $clog2(2 * WORD_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_TAIL
    } xfer_st_e;

    typedef struct packed {
        xfer_st_e            st;
        logic                cs_n;
        logic                sclk;
        logic                hold;
        logic [FMT_W-1:0]    fmt;
        logic [WORD_W-1:0]   data;
        logic [WORD_W-1:0]   tx;
        logic [WORD_W-1:0]   rx;
        logic [WORD_W-1:0]   rx_buf;
        logic [EDGE_W-1:0]   edge_cnt;
        logic                done;
    } engine_t;
endpackage

// File: rtl/spi_hold_clkdiv.sv
module spi_hold_clkdiv #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_tick_only_running_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);
endmodule

// File: rtl/spi_hold_fmt_sel.sv
module spi_hold_fmt_sel
    import spi_hold_pkg::*;
#(
    parameter logic [NFMT-1:0] FMT_CPOL = 4'b1010
) (
    input  logic [FMT_W-1:0] sel,
    output logic             cpol
);
    logic [NFMT-1:0] hit;

    for (genvar g = 0; g < NFMT; g++) begin : g_fmt
        assign hit[g] = (sel == FMT_W'(g)) && FMT_CPOL[g];
    end

    assign cpol = |hit;
endmodule

// File: rtl/spi_hold_engine.sv
module spi_hold_engine
    import spi_hold_pkg::*;
#(
    parameter logic RST_CPOL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              cpol_new,
    input  logic              tick,
    input  logic              miso,
    output logic [FMT_W-1:0]  fmt_cur,
    output logic              running,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              done,
    output logic [WORD_W-1:0] rx_data
);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * WORD_W - 1);

    engine_t q, d;
    logic          ctrl_wr, data_wr;
    logic [WORD_W-1:0] merged;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        ctrl_wr = wr_en && wr_be[CTRL_LANE];
        data_wr = wr_en && (wr_be[DATA_LANES-1:0] != '0);
        merged  = q.data;
        for (int i = 0; i < DATA_LANES; i++) begin
            if (wr_be[i]) merged[i*8 +: 8] = wr_data[i*8 +: 8];
        end
        case (q.st)
            ST_IDLE: begin
                if (ctrl_wr) begin
                    d.hold = wr_data[HOLD_BIT];
                    d.fmt  = wr_data[FMT_LSB +: FMT_W];
                    d.sclk = cpol_new;
                    if (!data_wr && !wr_data[HOLD_BIT]) d.cs_n = 1'b1;
                end
                if (data_wr) begin
                    d.data     = merged;
                    d.tx       = merged;
                    d.cs_n     = 1'b0;
                    d.edge_cnt = '0;
                    d.st       = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    d.sclk     = ~q.sclk;
                    d.edge_cnt = q.edge_cnt + 1'b1;
                    if (!q.edge_cnt[0]) d.rx = {q.rx[WORD_W-2:0], miso};
                    else                d.tx = {q.tx[WORD_W-2:0], 1'b0};
                    if (q.edge_cnt == LAST_EDGE) d.st = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    d.cs_n   = ~q.hold;
                    d.done   = 1'b1;
                    d.rx_buf = q.rx;
                    d.st     = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
            q.sclk <= RST_CPOL;
        end else begin
            q <= d;
        end
    end

    assign fmt_cur = q.fmt;
    assign running = (q.st != ST_IDLE);
    assign sclk    = q.sclk;
    assign mosi    = q.tx[WORD_W-1];
    assign cs_n    = q.cs_n;
    assign done    = q.done;
    assign rx_data = q.rx_buf;

    p_cs_low_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !cs_n);
    p_done_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_ctrl_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !running && (wr_be[DATA_LANES-1:0] == '0)) |=> !running);
    p_ctrl_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !running && wr_be[CTRL_LANE] && (wr_be[DATA_LANES-1:0] == '0)
         && !wr_data[HOLD_BIT]) |=> cs_n);
    p_held_word_keeps_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && q.hold) |=> !cs_n);
    p_sclk_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_en) |=> $stable(sclk));
    p_sclk_only_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && !tick) |=> $stable(sclk));
    p_fmt_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> $stable(fmt_cur));
endmodule

// File: rtl/spi_hold_master.sv
module spi_hold_master
    import spi_hold_pkg::*;
#(
    parameter int unsigned     HALF_DIV = 2,
    parameter logic [NFMT-1:0] FMT_CPOL = 4'b1010
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    input  logic        miso,
    output logic        sclk,
    output logic        mosi,
    output logic        cs_n,
    output logic        busy,
    output logic        done,
    output logic [15:0] rx_data
);
    logic [FMT_W-1:0] fmt_cur, fmt_sel;
    logic             cpol_new, tick, running;

    assign fmt_sel = wr_be[CTRL_LANE] ? wr_data[FMT_LSB +: FMT_W] : fmt_cur;

    spi_hold_fmt_sel #(.FMT_CPOL(FMT_CPOL)) u_fmt (
        .sel  (fmt_sel),
        .cpol (cpol_new)
    );

    spi_hold_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .tick  (tick)
    );

    spi_hold_engine #(.RST_CPOL(FMT_CPOL[0])) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_be    (wr_be),
        .wr_data  (wr_data),
        .cpol_new (cpol_new),
        .tick     (tick),
        .miso     (miso),
        .fmt_cur  (fmt_cur),
        .running  (running),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n),
        .done     (done),
        .rx_data  (rx_data)
    );

    assign busy = running;
endmodule

// File: tb/spi_hold_master_bench.sv
module spi_hold_master_bench;
    localparam int unsigned HALF_DIV = 2;
    localparam logic [3:0]  FMT_CPOL = 4'b1010;

    // vector: {hold, fmt[1:0], tx[15:0], rx[15:0]}
    localparam int NVEC = 6;
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 16'hA5C3, 16'h3C5A},
        {1'b0, 2'd1, 16'h1234, 16'hFEDC},
        {1'b0, 2'd2, 16'hFFFF, 16'h0000},
        {1'b1, 2'd3, 16'h0001, 16'h8000},
        {1'b1, 2'd0, 16'h8000, 16'h0001},
        {1'b0, 2'd0, 16'h0000, 16'hFFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic        miso = 1'b0;
    logic        sclk, mosi, cs_n, busy, done;
    logic [15:0] rx_data;

    always #2 clk = ~clk;

    spi_hold_master #(.HALF_DIV(HALF_DIV), .FMT_CPOL(FMT_CPOL)) u_spi_hold_master (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy),
        .done(done), .rx_data(rx_data)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // slave model
    logic [15:0] pat = '0;
    logic [15:0] cap = '0;
    int          ecnt = 0;
    bit          cnt_en = 1'b0;

    always @(sclk) begin
        if (cnt_en) begin
            ecnt = ecnt + 1;
            if (ecnt % 2 == 1) cap = {cap[14:0], mosi};
            else if (ecnt < 32) miso = pat[15 - ecnt/2];
        end
    end

    function automatic logic [31:0] pack(input logic hold, input logic [1:0] fmt,
                                         input logic [15:0] dat);
        return {3'b000, hold, 2'b00, fmt, 8'h00, dat};
    endfunction

    task automatic run_xfer(input logic [3:0] be, input logic [31:0] wdata,
                            input logic [15:0] exp_tx, input logic exp_hold,
                            input logic exp_cpol, input logic [15:0] rxw,
                            input bit poke);
        int n;
        int glitch;
        pat  = rxw;
        miso = rxw[15];
        cap  = '0;
        glitch = 0;
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = wdata;
        @(posedge clk);
        #1;
        ecnt = 0; cnt_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(busy == 1'b1, "R2 busy after data write", 32'(busy), 32'd1);
        check(cs_n == 1'b0, "R11 cs asserted at accept", 32'(cs_n), 32'd0);
        check(sclk == exp_cpol, "R8 idle level of format", 32'(sclk), 32'(exp_cpol));
        n = 0;
        while (sclk == exp_cpol && n < 64) begin
            @(negedge clk);
            n++;
            if (cs_n) glitch++;
        end
        check(n == HALF_DIV, "R11 first edge delay", 32'(n), 32'(HALF_DIV));
        if (poke) begin
            wr_en = 1'b1; wr_be = 4'hF;
            wr_data = pack(~exp_hold, 2'd1 ^ {1'b0, exp_cpol}, ~exp_tx);
            @(negedge clk);
            wr_en = 1'b0;
        end
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
            if (cs_n && !done) glitch++;
        end
        cnt_en = 1'b0;
        check(done == 1'b1, "R3 done raised", 32'(done), 32'd1);
        check(rx_data == rxw, "R3 received word", 32'(rx_data), 32'(rxw));
        check(cap == exp_tx, "R2 transmitted word", 32'(cap), 32'(exp_tx));
        check(ecnt == 32, "R8 sclk transition count", 32'(ecnt), 32'd32);
        check(cs_n == ~exp_hold, "R4 cs after word", 32'(cs_n), 32'(~exp_hold));
        check(glitch == 0, "R5 cs glitch count", 32'(glitch), 32'd0);
        check(sclk == exp_cpol, "R8 sclk back at idle", 32'(sclk), 32'(exp_cpol));
        @(negedge clk);
        check(done == 1'b0, "R3 done single cycle", 32'(done), 32'd0);
        check(busy == 1'b0, "R3 idle after done", 32'(busy), 32'd0);
    endtask

    task automatic ctrl_write(input logic [3:0] be, input logic [31:0] wdata);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = wdata;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(4 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1 cs_n reset", 32'(cs_n), 32'd1);
        check(busy == 1'b0, "R1 busy reset", 32'(busy), 32'd0);
        check(done == 1'b0, "R1 done reset", 32'(done), 32'd0);
        check(rx_data == 16'h0, "R1 rx_data reset", 32'(rx_data), 32'd0);
        check(sclk == FMT_CPOL[0], "R1 sclk reset", 32'(sclk), 32'(FMT_CPOL[0]));

        // table walk; vector 0 is the first write after reset (R9)
        for (int i = 0; i < NVEC; i++) begin
            logic        h = VEC[i][34];
            logic [1:0]  f = VEC[i][33:32];
            run_xfer(4'hF, pack(h, f, VEC[i][31:16]), VEC[i][31:16], h,
                     FMT_CPOL[f], VEC[i][15:0], 1'b0);
            if (i == 0)
                check(cs_n == 1'b0, "R9 first hold write honoured", 32'(cs_n), 32'd0);
        end

        // R2 single data lane keeps the other byte
        run_xfer(4'hF, pack(1'b1, 2'd0, 16'hAB00), 16'hAB00, 1'b1, FMT_CPOL[0], 16'h1357, 1'b0);
        run_xfer(4'b0001, 32'h0000_005C, 16'hAB5C, 1'b1, FMT_CPOL[0], 16'h2468, 1'b0);

        // R6 control-only write with hold set: no start, cs stays held
        s0 = sclk;
        ctrl_write(4'b1000, pack(1'b1, 2'd0, 16'h0000));
        check(busy == 1'b0, "R6 control write no start", 32'(busy), 32'd0);
        check(cs_n == 1'b0, "R6 held cs unchanged", 32'(cs_n), 32'd0);
        begin
            int toggles = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (sclk != s0) toggles++;
            end
            check(toggles == 0, "R6 no sclk activity", 32'(toggles), 32'd0);
        end

        // R7 control-only release, with a format switch to an idle-high polarity
        ctrl_write(4'b1000, pack(1'b0, 2'd1, 16'hFFFF));
        check(cs_n == 1'b1, "R7 control write releases cs", 32'(cs_n), 32'd1);
        check(busy == 1'b0, "R7 no transfer on release", 32'(busy), 32'd0);
        check(sclk == FMT_CPOL[1], "R8 idle level switched", 32'(sclk), 32'(FMT_CPOL[1]));

        // R6 write to a non-data, non-control lane starts nothing
        ctrl_write(4'b0100, 32'h00FF_0000);
        check(busy == 1'b0, "R6 lane2 write no start", 32'(busy), 32'd0);
        check(cs_n == 1'b1, "R6 lane2 write cs idle", 32'(cs_n), 32'd1);

        // R10 write while busy is ignored
        run_xfer(4'hF, pack(1'b0, 2'd1, 16'h6A95), 16'h6A95, 1'b0, FMT_CPOL[1], 16'hC3A5, 1'b1);
        check(sclk == FMT_CPOL[1], "R10 format unchanged by busy write", 32'(sclk),
              32'(FMT_CPOL[1]));

        report();
        $finish;
    end
endmodule